// File: doc/BRIEF.md
# Layered Interrupt Admission Gate

This block decides, cycle by cycle, whether the single interrupt request at its inputs may be taken by the core. The request carries a pending flag, a priority level and two class flags: non-maskable and hard fault. Three mask mechanisms can block it. A global mask blocks everything except non-maskable requests and hard faults. A fault-level mask blocks everything except non-maskable requests, hard faults included. A priority floor blocks any ordinary request whose priority is not strictly more urgent than the programmed floor. The admission decision is combinational from the request and the current register state.

The masks and a two-bit core control register (privilege level and stack selection) can be reached only through a dedicated special-register port. They cannot be used as ordinary data operands. Writes through that port are dropped while the control register marks the core as unprivileged. A lower priority number means a more urgent request, and a floor of zero switches the priority check off.

Top module: `irq_admit_gate`

## Requirements
- R1: After reset all four special registers read as zero (no masking, privileged, main stack), and a pending ordinary request of any priority is taken.
- R2: With the global mask set, an ordinary pending request is not taken, while non-maskable requests and hard faults still are.
- R3: With the fault-level mask set, ordinary requests and hard faults are not taken; non-maskable requests still are.
- R4: With a non-zero floor F, an ordinary request of priority P is taken only when P < F. Priorities equal to F or larger are blocked.
- R5: A floor of zero disables the priority check, so an ordinary request of any priority is admitted.
- R6: A pending non-maskable request is always taken, whatever the three masks hold.
- R7: The take output is low whenever no request is pending.
- R8: A write with select 0 (global mask, data bit 0), 1 (fault mask, data bit 0), 2 (floor, full width) or 3 (control) takes effect on the next clock edge. Reading with the same select returns the stored value, zero-extended.
- R9: While the control privilege bit (bit 0, 1 = unprivileged) is set, writes to every special register, the control register included, are ignored.
- R10: The control register holds the privilege bit in bit 0 and the stack-select bit in bit 1, and both read back as written.
- R11: A hard fault bypasses the global mask and the priority floor; only the fault-level mask blocks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Special-register write strobe |
| regWrSel | input | 2 | Write target: 0 global, 1 fault, 2 floor, 3 control |
| regWrData | input | PRIO_W | Write data |
| regRdSel | input | 2 | Read target, same encoding as the write select |
| regRdData | output | PRIO_W | Selected register, zero-extended |
| irqPending | input | 1 | A request is pending |
| irqPrio | input | PRIO_W | Request priority, lower is more urgent |
| irqIsNmi | input | 1 | Request is non-maskable |
| irqIsHardFault | input | 1 | Request is a hard fault |
| takeIrq | output | 1 | Request is admitted this cycle |

## Verification
A vector table tries each mask alone with ordinary, non-maskable and hard-fault requests, so every exemption rule is told apart from its neighbours. Floor vectors place the priority one below, equal to and one above the floor, and also use a floor of one, which separates a strict compare from an inclusive one. All masks set at once, with and without a pending request, separate the non-maskable bypass from the pending qualifier. Directed steps then read back the registers through the port, enter unprivileged mode, and confirm that later writes, including an attempt to leave that mode, change nothing.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

  typedef enum logic [1:0] {
    SEL_GLOBAL = 2'd0,
    SEL_FAULT  = 2'd1,
    SEL_FLOOR  = 2'd2,
    SEL_CTRL   = 2'd3
  } reg_sel_t;

  typedef struct packed {
    logic wrGlobal;
    logic wrFault;
    logic wrFloor;
    logic wrCtrl;
  } wr_strobe_t;

endpackage

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWrEn,
  input  irq_gate_pkg::reg_sel_t   regWrSel,
  input  logic                     ctrlUnpriv,
  output irq_gate_pkg::wr_strobe_t strb
);
  import irq_gate_pkg::*;

  logic wrAllowed;

  assign wrAllowed = regWrEn && !ctrlUnpriv;

  always_comb begin
    strb = '0;
    if (wrAllowed) begin
      unique case (regWrSel)
        SEL_GLOBAL: strb.wrGlobal = 1'b1;
        SEL_FAULT:  strb.wrFault  = 1'b1;
        SEL_FLOOR:  strb.wrFloor  = 1'b1;
        SEL_CTRL:   strb.wrCtrl   = 1'b1;
        default:    strb          = '0;
      endcase
    end
  end

  // R8: at most one register is targeted per write
  a_r8_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  // R9: no strobe leaves the control while unprivileged
  a_r9_no_strobe_unpriv: assert property (@(posedge clk) disable iff (!rstN)
    ctrlUnpriv |-> (strb == '0));

endmodule

// File: rtl/irq_gate_datapath.sv
module irq_gate_datapath #(
  parameter int PRIO_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  irq_gate_pkg::wr_strobe_t strb,
  input  logic [PRIO_W-1:0]        wrData,
  input  irq_gate_pkg::reg_sel_t   rdSel,
  output logic [PRIO_W-1:0]        rdData,
  output logic                     ctrlUnpriv,
  input  logic                     irqPending,
  input  logic [PRIO_W-1:0]        irqPrio,
  input  logic                     irqIsNmi,
  input  logic                     irqIsHardFault,
  output logic                     takeIrq
);
  import irq_gate_pkg::*;

  localparam int PAD_W = PRIO_W - 1;
  localparam int CTRL_PAD_W = PRIO_W - 2;

  logic              globalMask;
  logic              faultMask;
  logic [PRIO_W-1:0] prioFloor;
  logic              ctrlPsp;

  logic floorActive;
  logic passFloor;
  logic ordinaryOk;
  logic faultClassOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalMask <= 1'b0;
      faultMask  <= 1'b0;
      prioFloor  <= '0;
      ctrlUnpriv <= 1'b0;
      ctrlPsp    <= 1'b0;
    end else begin
      if (strb.wrGlobal) globalMask <= wrData[0];
      if (strb.wrFault)  faultMask  <= wrData[0];
      if (strb.wrFloor)  prioFloor  <= wrData;
      if (strb.wrCtrl) begin
        ctrlUnpriv <= wrData[0];
        ctrlPsp    <= wrData[1];
      end
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_GLOBAL: rdData = {{PAD_W{1'b0}}, globalMask};
      SEL_FAULT:  rdData = {{PAD_W{1'b0}}, faultMask};
      SEL_FLOOR:  rdData = prioFloor;
      SEL_CTRL:   rdData = {{CTRL_PAD_W{1'b0}}, ctrlPsp, ctrlUnpriv};
      default:    rdData = '0;
    endcase
  end

  assign floorActive  = (prioFloor != '0);
  assign passFloor    = !floorActive || (irqPrio < prioFloor);
  assign ordinaryOk   = !globalMask && passFloor;
  assign faultClassOk = !faultMask && (irqIsHardFault || ordinaryOk);
  assign takeIrq      = irqPending && (irqIsNmi || faultClassOk);

  // R7: nothing taken without a pending request
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !irqPending |-> !takeIrq);

  // R6: non-maskable requests always pass
  a_r6_nmi_taken: assert property (@(posedge clk) disable iff (!rstN)
    (irqPending && irqIsNmi) |-> takeIrq);

  // R3: fault-level mask leaves only non-maskable requests
  a_r3_fault_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (faultMask && !irqIsNmi) |-> !takeIrq);

  // R2: global mask blocks ordinary requests
  a_r2_global_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (globalMask && !irqIsNmi && !irqIsHardFault) |-> !takeIrq);

  // R9: register state frozen while unprivileged
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rstN)
    ctrlUnpriv |=> ($stable(globalMask) && $stable(faultMask) &&
                    $stable(prioFloor) && $stable(ctrlPsp) && ctrlUnpriv));

  // R8: floor write lands on the next edge
  a_r8_floor_write: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrFloor |=> (prioFloor == $past(wrData)));

endmodule

// File: rtl/irq_admit_gate.sv
module irq_admit_gate #(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regWrSel,
  input  logic [PRIO_W-1:0] regWrData,
  input  logic [1:0]        regRdSel,
  output logic [PRIO_W-1:0] regRdData,
  input  logic              irqPending,
  input  logic [PRIO_W-1:0] irqPrio,
  input  logic              irqIsNmi,
  input  logic              irqIsHardFault,
  output logic              takeIrq
);
  import irq_gate_pkg::*;

  wr_strobe_t strb;
  logic       ctrlUnpriv;

  irq_gate_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regWrSel   (reg_sel_t'(regWrSel)),
    .ctrlUnpriv (ctrlUnpriv),
    .strb       (strb)
  );

  irq_gate_datapath #(.PRIO_W(PRIO_W)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .wrData         (regWrData),
    .rdSel          (reg_sel_t'(regRdSel)),
    .rdData         (regRdData),
    .ctrlUnpriv     (ctrlUnpriv),
    .irqPending     (irqPending),
    .irqPrio        (irqPrio),
    .irqIsNmi       (irqIsNmi),
    .irqIsHardFault (irqIsHardFault),
    .takeIrq        (takeIrq)
  );

endmodule

// File: tb/sim_irq_admit_gate.sv
module sim_irq_admit_gate;

  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [1:0]    regWrSel = 2'd0;
  logic [PW-1:0] regWrData = '0;
  logic [1:0]    regRdSel = 2'd0;
  logic [PW-1:0] regRdData;
  logic          irqPending = 1'b0;
  logic [PW-1:0] irqPrio = '0;
  logic          irqIsNmi = 1'b0;
  logic          irqIsHardFault = 1'b0;
  logic          takeIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_admit_gate #(.PRIO_W(PW)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .regWrData(regWrData), .regRdSel(regRdSel), .regRdData(regRdData),
    .irqPending(irqPending), .irqPrio(irqPrio), .irqIsNmi(irqIsNmi),
    .irqIsHardFault(irqIsHardFault), .takeIrq(takeIrq)
  );

  // fields: global, fault, floor[8], nmi, hardFault, pending, prio[8], expected
  localparam int NV = 17;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0,1'b0,8'd0,  1'b0,1'b0,1'b1,8'd200,1'b1}, // R5 floor zero
    {1'b0,1'b0,8'd0,  1'b0,1'b0,1'b0,8'd5,  1'b0}, // R7 idle
    {1'b1,1'b0,8'd0,  1'b0,1'b0,1'b1,8'd0,  1'b0}, // R2 ordinary blocked
    {1'b1,1'b0,8'd0,  1'b1,1'b0,1'b1,8'd9,  1'b1}, // R2 R6 nmi passes
    {1'b1,1'b0,8'd0,  1'b0,1'b1,1'b1,8'd9,  1'b1}, // R2 R11 hard fault passes
    {1'b0,1'b1,8'd0,  1'b0,1'b1,1'b1,8'd0,  1'b0}, // R3 hard fault blocked
    {1'b0,1'b1,8'd0,  1'b1,1'b0,1'b1,8'd0,  1'b1}, // R3 nmi passes
    {1'b0,1'b1,8'd0,  1'b0,1'b0,1'b1,8'd0,  1'b0}, // R3 ordinary blocked
    {1'b0,1'b0,8'd16, 1'b0,1'b0,1'b1,8'd15, 1'b1}, // R4 below floor
    {1'b0,1'b0,8'd16, 1'b0,1'b0,1'b1,8'd16, 1'b0}, // R4 equal floor
    {1'b0,1'b0,8'd16, 1'b0,1'b0,1'b1,8'd17, 1'b0}, // R4 above floor
    {1'b0,1'b0,8'd16, 1'b0,1'b1,1'b1,8'd200,1'b1}, // R11 hard fault over floor
    {1'b0,1'b0,8'd16, 1'b1,1'b0,1'b1,8'd255,1'b1}, // R6 nmi over floor
    {1'b0,1'b0,8'd1,  1'b0,1'b0,1'b1,8'd0,  1'b1}, // R4 floor one, prio zero
    {1'b0,1'b0,8'd1,  1'b0,1'b0,1'b1,8'd1,  1'b0}, // R4 floor one, prio one
    {1'b1,1'b1,8'd4,  1'b1,1'b0,1'b1,8'd100,1'b1}, // R6 all masks set
    {1'b1,1'b1,8'd4,  1'b1,1'b0,1'b0,8'd100,1'b0}  // R7 nmi not pending
  };

  task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [PW-1:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [PW-1:0] val);
    regRdSel = sel;
    #0.5;
    val = regRdData;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [PW-1:0] rv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int s = 0; s < 4; s++) begin
      readReg(s[1:0], rv);
      check($sformatf("R1 reset read sel %0d", s), rv, '0);
    end
    irqPending = 1'b1; irqPrio = 8'd255;
    #0.5;
    check("R1 take after reset", {7'd0, takeIrq}, 8'd1);

    // R2 R3 R4 R5 R6 R7 R11 via vector table
    for (int i = 0; i < NV; i++) begin
      writeReg(2'd0, {7'd0, VEC[i][21]});
      writeReg(2'd1, {7'd0, VEC[i][20]});
      writeReg(2'd2, VEC[i][19:12]);
      irqIsNmi = VEC[i][11];
      irqIsHardFault = VEC[i][10];
      irqPending = VEC[i][9];
      irqPrio = VEC[i][8:1];
      #0.5;
      check($sformatf("gate vector %0d (R2/R3/R4/R5/R6/R7/R11)", i),
            {7'd0, takeIrq}, {7'd0, VEC[i][0]});
    end
    irqIsNmi = 1'b0; irqIsHardFault = 1'b0;

    // R8: read back, zero extension
    writeReg(2'd2, 8'hA5);
    readReg(2'd2, rv); check("R8 floor readback", rv, 8'hA5);
    writeReg(2'd0, 8'hFF);
    readReg(2'd0, rv); check("R8 global readback bit0 only", rv, 8'h01);
    writeReg(2'd1, 8'hFE);
    readReg(2'd1, rv); check("R8 fault readback bit0 only", rv, 8'h00);

    // R10: control bits
    writeReg(2'd3, 8'h02);
    readReg(2'd3, rv); check("R10 stack select readback", rv, 8'h02);
    writeReg(2'd3, 8'h03);
    readReg(2'd3, rv); check("R10 unprivileged readback", rv, 8'h03);

    // R9: writes ignored while unprivileged
    writeReg(2'd2, 8'h33);
    readReg(2'd2, rv); check("R9 floor unchanged", rv, 8'hA5);
    writeReg(2'd0, 8'h00);
    readReg(2'd0, rv); check("R9 global unchanged", rv, 8'h01);
    writeReg(2'd1, 8'h01);
    readReg(2'd1, rv); check("R9 fault unchanged", rv, 8'h00);
    writeReg(2'd3, 8'h00);
    readReg(2'd3, rv); check("R9 control unchanged", rv, 8'h03);
    irqPending = 1'b1; irqPrio = 8'd0;
    #0.5;
    check("R9 R2 global mask still blocks", {7'd0, takeIrq}, 8'd0);
    irqIsHardFault = 1'b1;
    #0.5;
    check("R9 R11 hard fault still passes", {7'd0, takeIrq}, 8'd1);

    finish();
  end

endmodule